// File: doc/BRIEF.md
# Sixteen-Line GPIO with Per-Line Interrupt Styles

This block gives software sixteen general-purpose lines behind a small register interface. Each line is either driven from an output data register or left as an input. A direction bit of 1 makes the line an input, so the output enable toward the pad is the inverse of that bit. Input levels pass through a two-flop synchronizer before they are read back or used for interrupt detection.

Each line has a 3-bit style field that selects how it raises an interrupt. The styles are active-high level, active-low level, rising edge, falling edge, and both edges. The fields for lines 0 to 7 sit in one style register and the fields for lines 8 to 15 in a second one. Detected events latch into a sticky status register that is cleared by writing ones. Each status bit drives its own interrupt output. A level-style event cannot be cleared while its line is still at the active level.

Register map, by 3-bit address: 0 direction, 1 output data, 2 input (read only), 3 style for lines 0–7, 4 style for lines 8–15, 5 status. A write takes effect at the clock edge where `wrEn` is high. A read is requested with `rdEn`, and `rdData` is valid with `rdValid` one cycle later.

Top module: `gpio_style_irq`

## Requirements
- R1: After reset every register is zero, so `pinOe` is all ones, `pinOut` is zero, `irqOut` is zero and the status register reads zero.
- R2: Direction register (address 0): bit n = 1 makes line n an input (`pinOe[n]` = 0); bit n = 0 makes it drive (`pinOe[n]` = 1). The register reads back as written.
- R3: Output data register (address 1) drives `pinOut` from the cycle after the write and reads back as written.
- R4: Input register (address 2) returns the synchronized level of each line, two clock edges after `pinIn` changes. Writes to it have no effect.
- R5: Address 3 holds the style fields of lines 0–7, address 4 those of lines 8–15. The field of a line occupies bits [3k+2:3k], where k is the line index within its group of eight. Bits 31:24 read as zero.
- R6: Style 0 (active high) sets the status bit while the synchronized input is 1.
- R7: Style 1 (active low) sets the status bit while the synchronized input is 0.
- R8: Style 2 sets the status bit on a 0-to-1 transition of the synchronized input, and style 3 on a 1-to-0 transition.
- R9: Style 4 sets the status bit on either transition.
- R10: Style values 5, 6 and 7 never set the status bit.
- R11: Status register (address 5) bits are sticky. Writing 1 to a bit clears it unless a new event occurs in the same cycle. Writing 0 leaves the bit unchanged.
- R12: A status bit of a level-style line stays set through a clear while its line is at the active level. Once the line has left the active level, the same clear removes it.
- R13: `irqOut[n]` equals status bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read request |
| addr | input | 3 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| pinIn | input | 16 | Line levels from the pads |
| pinOut | output | 16 | Output data toward the pads |
| pinOe | output | 16 | Per-line drive enable (1 = drive) |
| irqOut | output | 16 | Per-line interrupt requests |

## Verification
The hardest situation to produce is a clear written while a level-style line is still active. Two things must be shown: the clear has no effect then, and the same clear succeeds once the line has returned to its inactive level. The stimulus first configures active-low and active-high lines and holds them at their active levels. It then writes all ones to the status register and reads it back. After that it moves the lines to their inactive levels and clears again. The expected value combines the edge lines, whose bits must drop, with the level lines, whose bits must survive. Because of this, a single read tells apart a design that clears level bits unconditionally from one that never clears them.

// File: rtl/gpio_style_pkg.sv
package gpio_style_pkg;
  localparam int ADDR_W  = 3;
  localparam int STYLE_W = 3;

  // register addresses
  localparam logic [ADDR_W-1:0] SEL_DIR      = 3'd0;
  localparam logic [ADDR_W-1:0] SEL_OUT      = 3'd1;
  localparam logic [ADDR_W-1:0] SEL_IN       = 3'd2;
  localparam logic [ADDR_W-1:0] SEL_STYLE_LO = 3'd3;
  localparam logic [ADDR_W-1:0] SEL_STYLE_HI = 3'd4;
  localparam logic [ADDR_W-1:0] SEL_STATUS   = 3'd5;

  // style field encodings
  localparam logic [STYLE_W-1:0] STY_HIGH = 3'd0;
  localparam logic [STYLE_W-1:0] STY_LOW  = 3'd1;
  localparam logic [STYLE_W-1:0] STY_RISE = 3'd2;
  localparam logic [STYLE_W-1:0] STY_FALL = 3'd3;
  localparam logic [STYLE_W-1:0] STY_BOTH = 3'd4;

  typedef struct packed {
    logic              wrDir;
    logic              wrOut;
    logic              wrStyleLo;
    logic              wrStyleHi;
    logic              wrClr;
    logic              rdEn;
    logic [ADDR_W-1:0] rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_style_ctrl.sv
module gpio_style_ctrl
  import gpio_style_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobe_t       strobe
);
  always_comb begin
    strobe       = '0;
    strobe.rdEn  = rdEn;
    strobe.rdSel = addr;
    if (wrEn) begin
      case (addr)
        SEL_DIR:      strobe.wrDir     = 1'b1;
        SEL_OUT:      strobe.wrOut     = 1'b1;
        SEL_STYLE_LO: strobe.wrStyleLo = 1'b1;
        SEL_STYLE_HI: strobe.wrStyleHi = 1'b1;
        SEL_STATUS:   strobe.wrClr     = 1'b1;
        default:      ; // input register and unused addresses ignore writes
      endcase
    end
  end
endmodule

// File: rtl/gpio_style_datapath.sv
module gpio_style_datapath
  import gpio_style_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] irqOut,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdValid
);
  localparam int GROUP       = NUM_PINS / 2;
  localparam int STYLE_REG_W = GROUP * STYLE_W;

  logic [NUM_PINS-1:0]    dirReg, outReg, syncA, syncB, prevB, status;
  logic [STYLE_REG_W-1:0] styleLo, styleHi;
  logic [STYLE_W-1:0]     pinStyle [NUM_PINS];
  logic [NUM_PINS-1:0]    evt, levelNow, clrMask;
  logic [DATA_W-1:0]      rdNext;
  logic                   unusedBits;

  assign unusedBits = ^wrData[DATA_W-1:STYLE_REG_W];
  assign clrMask    = strobe.wrClr ? wrData[NUM_PINS-1:0] : '0;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg  <= '0;
      outReg  <= '0;
      styleLo <= '0;
      styleHi <= '0;
    end else begin
      if (strobe.wrDir)     dirReg  <= wrData[NUM_PINS-1:0];
      if (strobe.wrOut)     outReg  <= wrData[NUM_PINS-1:0];
      if (strobe.wrStyleLo) styleLo <= wrData[STYLE_REG_W-1:0];
      if (strobe.wrStyleHi) styleHi <= wrData[STYLE_REG_W-1:0];
    end
  end

  // two-flop synchronizer plus one history stage for edges
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  // per-line style selection and event detection
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    if (i < GROUP) begin : g_lo
      assign pinStyle[i] = styleLo[i*STYLE_W +: STYLE_W];
    end else begin : g_hi
      assign pinStyle[i] = styleHi[(i-GROUP)*STYLE_W +: STYLE_W];
    end

    always_comb begin
      evt[i]      = 1'b0;
      levelNow[i] = 1'b0;
      case (pinStyle[i])
        STY_HIGH: begin evt[i] = syncB[i];  levelNow[i] = syncB[i];  end
        STY_LOW:  begin evt[i] = !syncB[i]; levelNow[i] = !syncB[i]; end
        STY_RISE: evt[i] = syncB[i] && !prevB[i];
        STY_FALL: evt[i] = !syncB[i] && prevB[i];
        STY_BOTH: evt[i] = syncB[i] ^ prevB[i];
        default:  ;
      endcase
    end

    // R10: a disabled style cannot raise a clear status bit
    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
      (pinStyle[i] > STY_BOTH && !status[i]) |=> !status[i]);
  end

  // sticky status, set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~clrMask) | evt;
  end

  // registered read port
  always_comb begin
    case (strobe.rdSel)
      SEL_DIR:      rdNext = DATA_W'(dirReg);
      SEL_OUT:      rdNext = DATA_W'(outReg);
      SEL_IN:       rdNext = DATA_W'(syncB);
      SEL_STYLE_LO: rdNext = DATA_W'(styleLo);
      SEL_STYLE_HI: rdNext = DATA_W'(styleHi);
      SEL_STATUS:   rdNext = DATA_W'(status);
      default:      rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.rdEn;
      if (strobe.rdEn) rdData <= rdNext;
    end
  end

  assign pinOut = outReg;
  assign pinOe  = ~dirReg;
  assign irqOut = status;

  assert_status_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrClr || (|status) |=> ((status & $past(status & ~clrMask)) == $past(status & ~clrMask)));

  assert_clear_takes_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrClr |=> ((status & $past(clrMask & ~evt)) == '0));

  assert_level_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrClr && |(clrMask & levelNow)) |=>
      ((status & $past(clrMask & levelNow)) == $past(clrMask & levelNow)));
endmodule

// File: rtl/gpio_style_irq.sv
module gpio_style_irq
  import gpio_style_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdValid,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] irqOut
);
  ctrlStrobe_t strobe;

  gpio_style_ctrl u_ctrl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .strobe (strobe)
  );

  gpio_style_datapath #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .irqOut  (irqOut),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

  assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == SEL_DIR) |=> (pinOe == ~$past(wrData[NUM_PINS-1:0])));
endmodule

// File: tb/gpio_style_irq_test.sv
module gpio_style_irq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdValid;
  logic [15:0] pinIn = '0;
  logic [15:0] pinOut, pinOe, irqOut;

  int tests = 0;
  int fails = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  gpio_style_irq uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // driver: issue a read and queue the expected value
  task automatic readReg(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic checkVec(input logic [15:0] act, input logic [15:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // monitor: pop and compare as read data appears
  always @(negedge clk) begin
    if (rdValid) begin
      tests++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL unexpected read: actual %h expected none", rdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rdData !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, rdData, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkVec(pinOe, 16'hFFFF, "R1 pinOe");
    checkVec(pinOut, 16'h0000, "R1 pinOut");
    checkVec(irqOut, 16'h0000, "R1 irqOut");
    readReg(3'd5, 32'h0, "R1 status");
    readReg(3'd0, 32'h0, "R1 dir");

    // R2, R3 direction and output data
    writeReg(3'd0, 32'h0000_00F0);
    writeReg(3'd1, 32'h0000_A55A);
    checkVec(pinOe, 16'hFF0F, "R2 pinOe");
    checkVec(pinOut, 16'hA55A, "R3 pinOut");
    readReg(3'd0, 32'h0000_00F0, "R2 dir readback");
    readReg(3'd1, 32'h0000_A55A, "R3 out readback");

    // R5 disable all styles, readback masks upper bits
    writeReg(3'd3, 32'hFFFF_FFFF);
    writeReg(3'd4, 32'hFFFF_FFFF);
    readReg(3'd3, 32'h00FF_FFFF, "R5 style lo");
    readReg(3'd4, 32'h00FF_FFFF, "R5 style hi");

    // R4 input register, R10 disabled styles stay quiet
    pinIn = 16'h1234;
    settle();
    readReg(3'd2, 32'h0000_1234, "R4 input");
    writeReg(3'd2, 32'h0000_FFFF);
    readReg(3'd2, 32'h0000_1234, "R4 write ignored");
    readReg(3'd5, 32'h0, "R10 disabled no status");
    pinIn = 16'h0000;
    settle();

    // styles: p0 high, p1 low, p2 rise, p3 fall, p4 both, p8 high, rest disabled
    writeReg(3'd3, 32'h00FF_C688);
    writeReg(3'd4, 32'h00FF_FFF8);
    readReg(3'd3, 32'h00FF_C688, "R5 style lo fields");
    settle();
    readReg(3'd5, 32'h0000_0002, "R7 active low");
    writeReg(3'd5, 32'h0000_0002);
    readReg(3'd5, 32'h0000_0002, "R12 level clear blocked");

    // rising pattern, pin 12 disabled
    pinIn = 16'h111F;
    settle();
    readReg(3'd5, 32'h0000_0117, "R6 R8 R9 R10 rising events");
    checkVec(irqOut, 16'h0117, "R13 irq mirrors status");

    writeReg(3'd5, 32'h0000_FFFF);
    readReg(3'd5, 32'h0000_0101, "R11 R12 clear edges keep active levels");
    writeReg(3'd5, 32'h0000_0000);
    readReg(3'd5, 32'h0000_0101, "R11 zero write no effect");
    checkVec(irqOut, 16'h0101, "R13 irq after clear");

    // falling pattern
    pinIn = 16'h0000;
    settle();
    readReg(3'd5, 32'h0000_011B, "R7 R8 R9 falling events");
    writeReg(3'd5, 32'h0000_FFFF);
    readReg(3'd5, 32'h0000_0002, "R12 inactive level clears");
    checkVec(irqOut, 16'h0002, "R13 irq final");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      tests++;
      fails++;
      $display("FAIL reads outstanding: actual %0d expected 0", expQ.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule